// File: doc/BRIEF.md
# Fractional PLL output rate calculator

This block works out the output frequency that a fractional-N PLL will produce for a given set of divider settings and a given reference frequency. The settings are a multiplier, a pre-divider, a power-of-two post-divider shift and a signed fractional term in units of 1/65536 of the multiplier step. The block forms the scaled numerator and the divisor in one cycle. A restoring divider that resolves one quotient bit per clock then produces the rate in Hz.

The caller applies the operands together with a one-cycle start strobe while the block is idle. After a fixed latency the block raises a one-cycle done pulse and presents the rate, together with an error flag. Both stay unchanged until the next computation completes. A mode input selects integer-only operation, in which the fractional term plays no part. Illegal divisors and negative numerators are reported through the error flag and are never divided.

The controller has three states. `ST_IDLE` waits for a strobe. An accepted strobe with legal operands moves it to `ST_CALC` (transition *launch*). An accepted strobe with illegal operands moves it straight to `ST_DONE` (transition *reject*). `ST_CALC` stays put for 64 steps and then moves to `ST_DONE` (transition *finish*). `ST_DONE` always returns to `ST_IDLE` on the next clock (transition *retire*).

Top module: `frac_rate_calc`

## Requirements
- R1: In fractional mode (`frac_en_i`=1), a completed legal computation returns rate_o = floor((M·65536 + K)·Fin / ((P·65536)·2^S)), where M=`mult_i`, K=`frac_k_i`, P=`prediv_i`, S=`post_sh_i` and Fin=`ref_hz_i`.
- R2: In integer mode (`frac_en_i`=0), K is taken as zero whatever value is applied, so rate_o = floor(M·Fin / (P·2^S)).
- R3: K is a two's-complement 16-bit value covering −32768 to 32767, so a negative K lowers the rate below the integer setting.
- R4: The post-divider shift S divides the rate by 2^S, for every S from 0 to 6.
- R5: The result is exact, with no overflow, over the full operand ranges (M up to 1023, K up to 32767, any 32-bit Fin), because intermediates are 64 bits wide.
- R6: When P is zero, the block does not divide. It returns rate_o=0 with err_o=1, and done_o pulses in the cycle right after the strobe.
- R7: In fractional mode, a numerator M·65536+K below zero (M=0 with negative K) is reported like R6: rate_o=0, err_o=1, done one cycle after the strobe.
- R8: For legal operands, done_o is high for exactly one cycle, 64 clock edges after the edge that accepted the strobe. A legal completion clears err_o.
- R9: rate_o and err_o change only at the edge that raises done_o, and hold from then until the next completion.
- R10: A start strobe that arrives during a computation, or during the done cycle, is ignored and does not change the result in progress.
- R11: After reset, rate_o=0, err_o=0 and done_o=0, and the block accepts a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that launches a computation when idle |
| frac_en_i | input | 1 | 1 = fractional mode, 0 = integer-only mode |
| mult_i | input | 10 | Multiplier M |
| prediv_i | input | 6 | Pre-divider P |
| post_sh_i | input | 3 | Post-divider shift S |
| frac_k_i | input | 16 | Signed fractional term K |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| rate_o | output | 64 | Computed output rate in Hz |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set when the last computation was rejected |

## Verification
The main function is tried with a fractional setting with positive K, the same setting in integer mode, and the most negative K. Together these separate correct use of K from a mode flag that is dropped or a sign that is lost. A sweep of S from 0 to 6 at fixed M and P exposes a misplaced shift. A run with every operand at its maximum, including Fin of all ones, exposes a truncated intermediate. The illegal cases are P=0 and M=0 with negative K in each mode. These tell the reject path apart from the normal path, and show that integer mode does not falsely reject. Strobes issued during a computation and during the done cycle show whether busy strobes leak into the result.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } frc_state_t;

endpackage

// File: rtl/frc_operand.sv
module frc_operand #(
    parameter int MUL_W  = 10,
    parameter int PRE_W  = 6,
    parameter int SH_W   = 3,
    parameter int FRAC_W = 16,
    parameter int REF_W  = 32,
    parameter int NUM_W  = 64,
    parameter int DIV_W  = PRE_W + FRAC_W + (1 << SH_W) - 1
) (
    input  logic              frac_en_i,
    input  logic [MUL_W-1:0]  mult_i,
    input  logic [PRE_W-1:0]  prediv_i,
    input  logic [SH_W-1:0]   post_sh_i,
    input  logic [FRAC_W-1:0] frac_k_i,
    input  logic [REF_W-1:0]  ref_hz_i,
    output logic [NUM_W-1:0]  num_o,
    output logic [DIV_W-1:0]  den_o,
    output logic              fault_o
);

    localparam int SCL_W = MUL_W + FRAC_W + 1;

    logic signed [SCL_W-1:0] base_s;
    logic signed [SCL_W-1:0] kext_s;
    logic signed [SCL_W-1:0] sum_s;
    logic [SCL_W-2:0]        mag;
    logic [NUM_W-1:0]        mag_w;
    logic [NUM_W-1:0]        ref_w;
    logic [DIV_W-1:0]        den_base;

    always_comb begin
        base_s   = $signed({1'b0, mult_i, {FRAC_W{1'b0}}});
        kext_s   = $signed({{(SCL_W-FRAC_W){frac_k_i[FRAC_W-1]}}, frac_k_i});
        sum_s    = frac_en_i ? (base_s + kext_s) : base_s;
        mag      = sum_s[SCL_W-2:0];
        mag_w    = {{(NUM_W-SCL_W+1){1'b0}}, mag};
        ref_w    = {{(NUM_W-REF_W){1'b0}}, ref_hz_i};
        num_o    = mag_w * ref_w;
        den_base = {{(DIV_W-PRE_W-FRAC_W){1'b0}}, prediv_i, {FRAC_W{1'b0}}};
        den_o    = den_base << post_sh_i;
        fault_o  = (prediv_i == '0) || sum_s[SCL_W-1];
    end

endmodule

// File: rtl/frc_divider.sv
module frc_divider #(
    parameter int NUM_W = 64,
    parameter int DIV_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DIV_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_nxt_o
);

    logic [DIV_W-1:0] rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [DIV_W-1:0] den_q;
    logic [DIV_W:0]   trial;
    logic [DIV_W:0]   diff;
    logic             take;
    logic [DIV_W-1:0] rem_nxt;

    always_comb begin
        trial     = {rem_q, quo_q[NUM_W-1]};
        diff      = trial - {1'b0, den_q};
        take      = (trial >= {1'b0, den_q});
        rem_nxt   = take ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
        quo_nxt_o = {quo_q[NUM_W-2:0], take};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= num_i;
            den_q <= den_i;
        end else if (step_i) begin
            rem_q <= rem_nxt;
            quo_q <= quo_nxt_o;
        end
    end

    // R5
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (rem_q < den_q));

endmodule

// File: rtl/frc_ctrl.sv
module frc_ctrl
    import frc_pkg::*;
#(
    parameter int STEPS = 64,
    parameter int CNT_W = $clog2(STEPS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fault_i,
    output logic idle_o,
    output logic load_o,
    output logic step_o,
    output logic commit_o,
    output logic reject_o,
    output logic done_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    frc_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load_o)          cnt_q <= '0;
        else if (step_o)          cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = fault_i ? ST_DONE : ST_CALC;
            ST_CALC: if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle_o   = (state_q == ST_IDLE);
        load_o   = idle_o && start_i && !fault_i;
        reject_o = idle_o && start_i && fault_i;
        step_o   = (state_q == ST_CALC);
        commit_o = step_o && (cnt_q == LAST);
        done_o   = (state_q == ST_DONE);
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // R10
    calc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && cnt_q != LAST) |=>
            (state_q == ST_CALC && cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/frac_rate_calc.sv
module frac_rate_calc #(
    parameter int MUL_W  = 10,
    parameter int PRE_W  = 6,
    parameter int SH_W   = 3,
    parameter int FRAC_W = 16,
    parameter int REF_W  = 32,
    parameter int NUM_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              frac_en_i,
    input  logic [MUL_W-1:0]  mult_i,
    input  logic [PRE_W-1:0]  prediv_i,
    input  logic [SH_W-1:0]   post_sh_i,
    input  logic [FRAC_W-1:0] frac_k_i,
    input  logic [REF_W-1:0]  ref_hz_i,
    output logic [NUM_W-1:0]  rate_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int DIV_W = PRE_W + FRAC_W + (1 << SH_W) - 1;

    logic [NUM_W-1:0] num_w;
    logic [DIV_W-1:0] den_w;
    logic [NUM_W-1:0] quo_nxt;
    logic fault_w, idle_w, load_w, step_w, commit_w, reject_w;

    frc_operand #(
        .MUL_W(MUL_W), .PRE_W(PRE_W), .SH_W(SH_W),
        .FRAC_W(FRAC_W), .REF_W(REF_W), .NUM_W(NUM_W), .DIV_W(DIV_W)
    ) u_opnd (
        .frac_en_i(frac_en_i), .mult_i(mult_i), .prediv_i(prediv_i),
        .post_sh_i(post_sh_i), .frac_k_i(frac_k_i), .ref_hz_i(ref_hz_i),
        .num_o(num_w), .den_o(den_w), .fault_o(fault_w)
    );

    frc_ctrl #(.STEPS(NUM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fault_i(fault_w),
        .idle_o(idle_w), .load_o(load_w), .step_o(step_w),
        .commit_o(commit_w), .reject_o(reject_w), .done_o(done_o)
    );

    frc_divider #(.NUM_W(NUM_W), .DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
        .num_i(num_w), .den_i(den_w), .quo_nxt_o(quo_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_o <= '0;
            err_o  <= 1'b0;
        end else if (reject_w) begin
            rate_o <= '0;
            err_o  <= 1'b1;
        end else if (commit_w) begin
            rate_o <= quo_nxt;
            err_o  <= 1'b0;
        end
    end

    // R6
    zero_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && start_i && prediv_i == '0) |=> (done_o && err_o && rate_o == '0));

    // R9
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(rate_o) && $stable(err_o)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/sim_frac_rate_calc.sv
module sim_frac_rate_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        frac_en_i = 1'b0;
    logic [9:0]  mult_i = '0;
    logic [5:0]  prediv_i = '0;
    logic [2:0]  post_sh_i = '0;
    logic [15:0] frac_k_i = '0;
    logic [31:0] ref_hz_i = '0;
    logic [63:0] rate_o;
    logic        done_o, err_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    frac_rate_calc u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frac_en_i(frac_en_i),
        .mult_i(mult_i), .prediv_i(prediv_i), .post_sh_i(post_sh_i),
        .frac_k_i(frac_k_i), .ref_hz_i(ref_hz_i),
        .rate_o(rate_o), .done_o(done_o), .err_o(err_o)
    );

    // Behavioural reference
    function automatic void ref_calc(input bit fe, input int m, input int p,
                                     input int s, input int k, input longint unsigned fin,
                                     output longint unsigned q, output bit e);
        longint sc;
        longint unsigned den;
        sc = longint'(m) * 65536 + (fe ? longint'(k) : 0);
        if (p == 0 || sc < 0) begin
            q = 0; e = 1'b1;
        end else begin
            den = (longint'(p) * 65536) << s;
            q = (longint'(unsigned'(sc)) * fin) / den;
            e = 1'b0;
        end
    endfunction

    int              m_cnt = 0;
    bit              m_done = 0, m_err = 0, m_perr = 0;
    longint unsigned m_rate = 0, m_pend = 0;

    always @(posedge clk) begin
        bit busy;
        longint unsigned q;
        bit e;
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_err = 0; m_rate = 0;
        end else begin
            busy = (m_cnt > 0) || m_done;
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_rate = m_pend; m_err = 0;
                end
            end else if (start_i && !busy) begin
                ref_calc(frac_en_i, int'(mult_i), int'(prediv_i), int'(post_sh_i),
                         int'($signed(frac_k_i)), longint'(ref_hz_i), q, e);
                if (e) begin
                    m_done = 1; m_rate = 0; m_err = 1;
                end else begin
                    m_cnt = 64; m_pend = q;
                end
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (done_o !== m_done) begin
                bad++; $display("FAIL R8 done: actual=%0b expected=%0b", done_o, m_done);
            end
            total++;
            if (rate_o !== m_rate) begin
                bad++; $display("FAIL R1 rate: actual=%0d expected=%0d", rate_o, m_rate);
            end
            total++;
            if (err_o !== m_err) begin
                bad++; $display("FAIL R6 err: actual=%0b expected=%0b", err_o, m_err);
            end
        end
    end

    task automatic check(input string tag, input longint unsigned got, input longint unsigned exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic go(input bit fe, input int m, input int p, input int s,
                      input int k, input longint unsigned fin);
        @(negedge clk);
        frac_en_i = fe; mult_i = 10'(m); prediv_i = 6'(p);
        post_sh_i = 3'(s); frac_k_i = 16'(k); ref_hz_i = 32'(fin);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run(input string tag, input bit fe, input int m, input int p,
                       input int s, input int k, input longint unsigned fin);
        longint unsigned q;
        bit e;
        ref_calc(fe, m, p, s, k, fin, q, e);
        go(fe, m, p, s, k, fin);
        repeat (70) @(negedge clk);
        check(tag, rate_o, q);
        check(tag, longint'(err_o), longint'(e));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL R8 watchdog: cycles=%0d expected below 100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint unsigned q_keep;
        bit e_keep;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rate", rate_o, 0);
        check("R11 err", longint'(err_o), 0);
        check("R11 done", longint'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run("R1 frac", 1, 173, 2, 1, 16384, 24000000);
        run("R2 int ignores K", 0, 173, 2, 1, 16384, 24000000);
        run("R3 negative K", 1, 361, 3, 3, -32768, 24000000);
        run("R3 small negative K", 1, 262, 2, 3, -1, 24000000);
        for (int s = 0; s <= 6; s++) run("R4 shift", 1, 250, 3, s, 9437, 24000000);
        run("R5 max", 1, 1023, 1, 0, 32767, 64'hFFFF_FFFF);
        run("R5 max int", 0, 1023, 1, 0, 32767, 64'hFFFF_FFFF);

        // R6 zero pre-divider: done one cycle later
        go(1, 200, 0, 1, 0, 24000000);
        check("R6 done next cycle", longint'(done_o), 1);
        check("R6 err", longint'(err_o), 1);
        check("R6 rate zero", rate_o, 0);
        repeat (3) @(negedge clk);
        run("R8 err cleared", 1, 300, 3, 1, 0, 24000000);

        // R7 negative numerator
        go(1, 0, 2, 0, -1, 24000000);
        check("R7 done", longint'(done_o), 1);
        check("R7 err", longint'(err_o), 1);
        repeat (3) @(negedge clk);
        run("R7 int mode not rejected", 0, 0, 2, 0, -1, 24000000);

        // R10 strobe while computing
        ref_calc(1, 325, 3, 2, 0, 24000000, q_keep, e_keep);
        go(1, 325, 3, 2, 0, 24000000);
        repeat (10) @(negedge clk);
        go(1, 100, 1, 0, 0, 25000000);
        repeat (70) @(negedge clk);
        check("R10 busy strobe ignored", rate_o, q_keep);

        // R10 strobe during the done cycle
        go(1, 198, 2, 2, 0, 24000000);
        while (!done_o) @(negedge clk);
        start_i = 1'b1; mult_i = 10'd999;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 done-cycle strobe ignored", longint'(done_o), 0);
        repeat (70) @(negedge clk);
        ref_calc(1, 198, 2, 2, 0, 24000000, q_keep, e_keep);
        check("R9 result held", rate_o, q_keep);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule